// File: doc/BRIEF.md
# Two-Half Pixel Assembler with Dual-Clock Buffer

This block sits behind a link deserialiser. It turns a stream of 18-bit link words into 32-bit pixels and holds them for a downstream pipeline that runs on its own pixel clock. Each link word carries a 16-bit payload and a 2-bit tag. The tag marks the word as the lower half of a pixel, the upper half, or neither. A pixel is complete when an upper half follows a lower half. The finished pixel is stored in a dual-clock buffer that is 4096 entries deep.

The pixel pipeline pulls pixels one at a time with a request strobe. The buffer returns a pixel with a valid flag one pixel-clock cycle later. On the link side, an occupancy flag tells the sender to pause before the buffer overflows. Halves that arrive out of order are thrown away and set a sticky framing-error flag. Each clock domain has its own active-low reset. The reset is asserted asynchronously and released synchronously inside the block.

Top module: `pwa_fifo`

## Requirements
- R1: Tag `link_word[17:16]` is decoded as 2'b01 = lower half and 2'b10 = upper half. Tags 2'b00 and 2'b11 have no effect: a lower half that is waiting for its partner stays pending across them.
- R2: An upper half that arrives while a lower half is pending produces the pixel {upper[15:0], lower[15:0]}. This clears the pending state.
- R3: An upper half that arrives with no lower half pending is discarded and sets `frame_err`.
- R4: A lower half that arrives while another lower half is pending discards both halves. It leaves nothing pending and sets `frame_err`.
- R5: Once set, `frame_err` stays high until the write-side reset.
- R6: Pixels leave in the order they were written. The buffer holds up to 4096 pixels. A pixel completed while the buffer is full is discarded.
- R7: `link_afull` is high while the write-side occupancy is at least AFULL_LEVEL (default 4032). It is low otherwise. It is registered, so it follows the occupancy one write-clock cycle later.
- R8: When `rd_req` is high at a pixel-clock edge and the buffer is not empty, `pix_data` holds the oldest pixel and `pix_valid` is high in the following cycle.
- R9: When `rd_req` is high and the buffer is empty, `pix_valid` stays low and no pixel is consumed.
- R10: After reset, `link_afull`, `frame_err` and `pix_valid` are low, both pointers are cleared and no lower half is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Link word clock |
| wrst_n | input | 1 | Link-side active-low reset |
| link_word | input | 18 | Tag in [17:16], payload in [15:0] |
| link_afull | output | 1 | Occupancy at or above threshold, back to the sender |
| frame_err | output | 1 | Sticky out-of-order half flag |
| rclk | input | 1 | Pixel clock |
| rrst_n | input | 1 | Pixel-side active-low reset |
| rd_req | input | 1 | Pixel request from the pipeline |
| pix_data | output | 32 | Assembled pixel |
| pix_valid | output | 1 | `pix_data` holds a pixel this cycle |

## Verification
The assertions assume that both resets are applied together, so the pointers never start out of step. They also assume that `link_word` and `rd_req` are steady around their own clock edges. The stimulus changes every input only on the falling edge of its clock.

The stimulus resets both sides before each scenario. It waits for the pointer synchronisers to settle before it checks occupancy-dependent outputs. It also keeps reading until the buffer is empty, so the empty and full boundaries are reached on purpose rather than by chance.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  typedef enum logic [1:0] {
    TAG_NONE  = 2'b00,
    TAG_LOWER = 2'b01,
    TAG_UPPER = 2'b10,
    TAG_SPARE = 2'b11
  } half_tag_e;

  localparam int HALF_W = 16;
  localparam int PIX_W  = 2 * HALF_W;
  localparam int WORD_W = HALF_W + 2;
endpackage

// File: rtl/pwa_join.sv
module pwa_join
  import pwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  output logic              px_we,
  output logic [PIX_W-1:0]  px_data,
  output logic              ferr
);
  logic              pend_q, pend_d;
  logic [HALF_W-1:0] lower_q;
  logic              lower_en;
  logic              ferr_q, ferr_d;
  half_tag_e         tag;

  assign tag = half_tag_e'(word[WORD_W-1:HALF_W]);

  always_comb begin
    pend_d   = pend_q;
    ferr_d   = ferr_q;
    lower_en = 1'b0;
    px_we    = 1'b0;
    case (tag)
      TAG_LOWER: begin
        if (pend_q) begin
          pend_d = 1'b0;
          ferr_d = 1'b1;
        end else begin
          pend_d   = 1'b1;
          lower_en = 1'b1;
        end
      end
      TAG_UPPER: begin
        if (pend_q) begin
          px_we  = 1'b1;
          pend_d = 1'b0;
        end else begin
          ferr_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign px_data = {word[HALF_W-1:0], lower_q};
  assign ferr    = ferr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ferr_q <= ferr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lower_q <= '0;
    else if (lower_en)
      lower_q <= word[HALF_W-1:0];
  end

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |=> ferr);
  p_pair_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    px_we |=> !pend_q);
  p_lone_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tag == TAG_UPPER && !pend_q) |=> ferr);
  p_idle_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tag == TAG_NONE || tag == TAG_SPARE) |=> $stable(pend_q));
endmodule

// File: rtl/pwa_gray_sync.sv
module pwa_gray_sync #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/pwa_mem.sv
module pwa_mem #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/pwa_fifo.sv
module pwa_fifo
  import pwa_pkg::*;
#(
  parameter int AW          = 12,
  parameter int AFULL_LEVEL = (1 << AW) - 64
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic [WORD_W-1:0] link_word,
  output logic              link_afull,
  output logic              frame_err,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_req,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_valid
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] LEVEL_P = PW'(AFULL_LEVEL);

  // reset release synchronisers
  logic wr_s1, wr_s2, rr_s1, rr_s2;
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) {wr_s2, wr_s1} <= 2'b00;
    else         {wr_s2, wr_s1} <= {wr_s1, 1'b1};
  end
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) {rr_s2, rr_s1} <= 2'b00;
    else         {rr_s2, rr_s1} <= {rr_s1, 1'b1};
  end

  // write side
  logic             px_we;
  logic [PIX_W-1:0] px_data;
  logic [PW-1:0]    wbin_q, wbin_d, wgray_q, wgray_d, rbin_w, wocc;
  logic             wfull, wr_go, afull_q, afull_d;

  pwa_join u_join (
    .clk(wclk), .rst_n(wr_s2), .word(link_word),
    .px_we(px_we), .px_data(px_data), .ferr(frame_err)
  );

  pwa_gray_sync #(.W(PW)) u_rsync (
    .clk(wclk), .rst_n(wr_s2), .gray_in(rgray_q), .bin_out(rbin_w)
  );

  always_comb begin
    wocc    = wbin_q - rbin_w;
    wfull   = (wocc == DEPTH_P);
    wr_go   = px_we && !wfull;
    wbin_d  = wr_go ? wbin_q + 1'b1 : wbin_q;
    wgray_d = wbin_d ^ (wbin_d >> 1);
    afull_d = (wocc >= LEVEL_P);
  end

  always_ff @(posedge wclk or negedge wr_s2) begin
    if (!wr_s2) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      afull_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      afull_q <= afull_d;
    end
  end

  assign link_afull = afull_q;

  // read side
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_r;
  logic          rempty, rd_go, valid_q, valid_d;

  pwa_gray_sync #(.W(PW)) u_wsync (
    .clk(rclk), .rst_n(rr_s2), .gray_in(wgray_q), .bin_out(wbin_r)
  );

  always_comb begin
    rempty  = (rbin_q == wbin_r);
    rd_go   = rd_req && !rempty;
    rbin_d  = rd_go ? rbin_q + 1'b1 : rbin_q;
    rgray_d = rbin_d ^ (rbin_d >> 1);
    valid_d = rd_go;
  end

  always_ff @(posedge rclk or negedge rr_s2) begin
    if (!rr_s2) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      valid_q <= valid_d;
    end
  end

  assign pix_valid = valid_q;

  pwa_mem #(.AW(AW), .DW(PIX_W)) u_mem (
    .wclk(wclk), .we(wr_go), .waddr(wbin_q[AW-1:0]), .wdata(px_data),
    .rclk(rclk), .re(rd_go), .raddr(rbin_q[AW-1:0]), .rdata(pix_data)
  );

  p_no_overflow_r6: assert property (@(posedge wclk) disable iff (!wr_s2)
    wocc <= DEPTH_P);
  p_gray_step_r6: assert property (@(posedge wclk) disable iff (!wr_s2)
    1'b1 |=> $countones(wgray_q ^ $past(wgray_q)) <= 1);
  p_afull_track_r7: assert property (@(posedge wclk) disable iff (!wr_s2)
    (wocc < LEVEL_P) |=> !link_afull);
  p_valid_needs_req_r8: assert property (@(posedge rclk) disable iff (!rr_s2)
    pix_valid |-> $past(rd_req));
  p_empty_hold_r9: assert property (@(posedge rclk) disable iff (!rr_s2)
    (rd_req && rempty) |=> ($stable(rbin_q) && !pix_valid));
endmodule

// File: tb/tb_pwa_fifo.sv
`timescale 1ns/1ps
module tb_pwa_fifo;
  logic        wclk = 0, rclk = 0;
  logic        wrst_n, rrst_n;
  logic [17:0] link_word;
  logic        rd_req;
  logic        link_afull, frame_err, pix_valid;
  logic [31:0] pix_data;

  int errors = 0;
  int checks = 0;
  int valid_seen = 0;
  logic [31:0] qexp[$];

  always #10 wclk = ~wclk;
  always #7  rclk = ~rclk;

  pwa_fifo dut (
    .wclk(wclk), .wrst_n(wrst_n), .link_word(link_word),
    .link_afull(link_afull), .frame_err(frame_err),
    .rclk(rclk), .rrst_n(rrst_n), .rd_req(rd_req),
    .pix_data(pix_data), .pix_valid(pix_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops on every valid pixel
  always @(negedge rclk) begin
    if (rrst_n && pix_valid === 1'b1) begin
      valid_seen++;
      checks++;
      if (qexp.size() == 0) begin
        errors++;
        $display("FAIL R9: actual=valid %h expected=no pixel", pix_data);
      end else begin
        logic [31:0] e;
        e = qexp.pop_front();
        if (pix_data !== e) begin
          errors++;
          $display("FAIL R6: actual=%h expected=%h", pix_data, e);
        end
      end
    end
  end

  task automatic send(input logic [1:0] tag, input logic [15:0] d);
    @(negedge wclk);
    link_word = {tag, d};
    @(negedge wclk);
    link_word = 18'h0;
  endtask

  task automatic push_pix(input logic [15:0] lo, input logic [15:0] hi, input bit expect_it);
    @(negedge wclk); link_word = {2'b01, lo};
    @(negedge wclk); link_word = {2'b10, hi};
    @(negedge wclk); link_word = 18'h0;
    if (expect_it) qexp.push_back({hi, lo});
  endtask

  task automatic rd_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk); rd_req = 1'b1;
    end
    @(negedge rclk); rd_req = 1'b0;
    repeat (3) @(negedge rclk);
  endtask

  task automatic do_reset();
    @(negedge wclk);
    wrst_n = 0; rrst_n = 0; rd_req = 0; link_word = 18'h0;
    qexp.delete();
    repeat (4) @(negedge wclk);
    wrst_n = 1; rrst_n = 1;
    repeat (6) @(negedge wclk);
  endtask

  initial begin
    #(20ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int vs;
    wrst_n = 0; rrst_n = 0; rd_req = 0; link_word = 18'h0;
    do_reset();
    // R10 reset state
    check("R10 afull", {31'b0, link_afull}, 32'd0);
    check("R10 ferr",  {31'b0, frame_err},  32'd0);
    check("R10 valid", {31'b0, pix_valid},  32'd0);

    // R2 and R1: basic pairs, idle tags between halves
    push_pix(16'h0000, 16'h0000, 1);
    push_pix(16'hFFFF, 16'hFFFF, 1);
    push_pix(16'hA5A5, 16'h5A5A, 1);
    send(2'b01, 16'h1234);
    send(2'b11, 16'hDEAD);
    send(2'b00, 16'hBEEF);
    send(2'b10, 16'h9876);
    qexp.push_back(32'h9876_1234); // R1 idle tags keep pending lower half
    push_pix(16'h0F0F, 16'hF0F0, 1);
    check("R1 no error from idle tags", {31'b0, frame_err}, 32'd0);
    repeat (8) @(negedge wclk);
    rd_burst(5);
    check("R2 all pixels delivered", qexp.size(), 32'd0);

    // R9: read when empty
    vs = valid_seen;
    rd_burst(6);
    check("R9 no valid on empty", valid_seen - vs, 32'd0);
    push_pix(16'h4321, 16'h8765, 1);
    repeat (8) @(negedge wclk);
    rd_burst(1);
    check("R9 pointer unmoved", qexp.size(), 32'd0);
    check("R8 one pixel returned", valid_seen - vs, 32'd1);

    // R3 lone upper half
    do_reset();
    send(2'b10, 16'h7777);
    check("R3 ferr set", {31'b0, frame_err}, 32'd1);
    push_pix(16'h1111, 16'h2222, 1);
    check("R5 ferr sticky", {31'b0, frame_err}, 32'd1);
    repeat (8) @(negedge wclk);
    vs = valid_seen;
    rd_burst(3);
    check("R3 only good pair stored", valid_seen - vs, 32'd1);

    // R10 clears error; R4 double lower
    do_reset();
    check("R10 ferr cleared", {31'b0, frame_err}, 32'd0);
    send(2'b01, 16'hAAAA);
    send(2'b01, 16'hBBBB);
    check("R4 ferr set", {31'b0, frame_err}, 32'd1);
    send(2'b10, 16'hCCCC);
    push_pix(16'h3333, 16'h4444, 1);
    repeat (8) @(negedge wclk);
    vs = valid_seen;
    rd_burst(3);
    check("R4 both lowers discarded", valid_seen - vs, 32'd1);
    check("R4 queue empty", qexp.size(), 32'd0);

    // R7 threshold and R6 full
    do_reset();
    for (int i = 0; i < 4031; i++)
      push_pix(i[15:0], i[15:0] ^ 16'h5A00, 1);
    repeat (10) @(negedge wclk);
    check("R7 below threshold", {31'b0, link_afull}, 32'd0);
    push_pix(16'd4031, 16'd4031 ^ 16'h5A00, 1);
    repeat (3) @(negedge wclk);
    check("R7 at threshold", {31'b0, link_afull}, 32'd1);
    for (int i = 4032; i < 4096; i++)
      push_pix(i[15:0], i[15:0] ^ 16'h5A00, 1);
    push_pix(16'hEEEE, 16'hEEEE, 0);
    push_pix(16'hDDDD, 16'hDDDD, 0);
    check("R7 still high when full", {31'b0, link_afull}, 32'd1);
    repeat (8) @(negedge wclk);
    vs = valid_seen;
    rd_burst(4100);
    check("R6 exactly depth pixels", valid_seen - vs, 32'd4096);
    check("R6 queue drained", qexp.size(), 32'd0);
    repeat (10) @(negedge wclk);
    check("R7 drops after drain", {31'b0, link_afull}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule